// File: doc/BRIEF.md
# 16-bit Free-Running Timer with Edge Capture

This block is a 16-bit up-counter that advances once per clock and starts from 16'hFFFC after reset. A processor reads it one byte at a time through a small register window. It can read the count through a main pair of byte registers or through an alternate pair. The alternate pair gives the same value but never touches the overflow flag. Reading either high byte freezes the matching low byte, so a high-then-low read always returns one coherent value.

One capture channel watches a clean digital input. The input first passes through a synchroniser. On the chosen edge, the block copies the count into a capture register and raises a capture flag. Reading the capture high byte holds the capture register until its low byte has been read, so the two bytes always belong together.

Each flag clears in two steps: a status read taken while the flag is set, followed by a read of the matching low byte. An interrupt line is raised while any enabled flag is set. A stop input freezes the count. A capture edge that arrives during stop is remembered and taken once counting resumes.

Top module: `cap_timer16`

## Requirements
- R1: After reset the count is 16'hFFFC, the status register (`sel`=1) reads zero, and the two enable bits of the control register (`sel`=0, bits 1:0) read zero.
- R2: While `stop_i` is low the count rises by exactly one per clock and wraps from 16'hFFFF to 16'h0000. Writes to any register other than control leave the count unchanged.
- R3: The count high byte sits at `sel`=2 and its low byte at `sel`=3. The alternate high byte sits at `sel`=4 and its low byte at `sel`=5. A high-byte read on either path freezes the low-byte view at the value it had at that read. The freeze lasts until a low byte is read, so a high read followed by a low read returns one 16-bit value.
- R4: Control bit 2 selects the capture edge: 1 selects a rising edge and 0 a falling edge. Reset does not change this bit. On the selected edge the block loads the count into the capture register and sets status bit 0. The opposite edge does nothing.
- R5: The overflow flag is status bit 1. It is set on the wrap from 16'hFFFF to 16'h0000. It is cleared by a status read taken while the flag is set, followed by a read of `sel`=3.
- R6: Reading the capture high byte (`sel`=6) blocks all further captures until the capture low byte (`sel`=7) has been read.
- R7: Reads of the alternate counter bytes never clear or change the overflow flag.
- R8: The capture flag is cleared by a status read taken while the flag is set, followed by a read of `sel`=7. A read of `sel`=7 with no such status read before it leaves the flag set.
- R9: While `stop_i` is high the count holds and no capture flag is set. A selected edge seen during stop is remembered. On the first clock with `stop_i` low, that edge is captured, using the held count.
- R10: `irq_o` is high exactly when the capture flag is set with control bit 0 set, or the overflow flag is set with control bit 1 set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 3 | Register select |
| rd_en | input | 1 | Read strobe; side effects of the read take place at the clock edge |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `sel`, valid in the same cycle |
| cap_in | input | 1 | Capture input, clean digital, asynchronous |
| stop_i | input | 1 | Freeze request for the counter |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a capture edge that arrives while the capture register is held, or while the counter is stopped. In both cases the edge must be timed against reads that take several cycles each. The bench drives a counter model of its own and toggles the input at known clock edges, allowing for the synchroniser delay. It sets the hold with a lone high-byte read, then sends edges that must be dropped or deferred. Only after that does it read the capture value and the flag back through the register window.

// File: rtl/cap_timer16_pkg.sv
package cap_timer16_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_STAT   = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_CNT_LO = 3'd3,
    REG_ALT_HI = 3'd4,
    REG_ALT_LO = 3'd5,
    REG_CAP_HI = 3'd6,
    REG_CAP_LO = 3'd7
  } reg_sel_e;

  // selected-edge detection: pol=1 rising, pol=0 falling
  function automatic logic edge_hit(input logic pol, input logic now_v, input logic prev_v);
    return pol ? (now_v & ~prev_v) : (~now_v & prev_v);
  endfunction
endpackage

// File: rtl/tm_counter.sv
module tm_counter #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             hi_rd,
  input  logic             lo_rd,
  input  logic             stat_rd,
  input  logic             main_lo_rd,
  output logic [CNT_W-1:0] cnt,
  output logic [cap_timer16_pkg::BYTE_W-1:0] lo_view,
  output logic             ovf_flag,
  output logic             wrap
);
  import cap_timer16_pkg::*;
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [BYTE_W-1:0] lo_buf;
  logic              lo_frozen;
  logic              ovf_arm;

  assign wrap = run && (cnt == ALL_ONES);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= RST_VAL;
    else if (run) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_buf    <= '0;
      lo_frozen <= 1'b0;
    end else if (hi_rd) begin
      lo_buf    <= cnt[BYTE_W-1:0];
      lo_frozen <= 1'b1;
    end else if (lo_rd) begin
      lo_frozen <= 1'b0;
    end
  end

  assign lo_view = lo_frozen ? lo_buf : cnt[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      ovf_arm  <= 1'b0;
    end else begin
      if (stat_rd && ovf_flag) ovf_arm <= 1'b1;
      if (main_lo_rd && ovf_arm) begin
        ovf_flag <= 1'b0;
        ovf_arm  <= 1'b0;
      end
      if (wrap) ovf_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tm_capture.sv
module tm_capture #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_raw,
  input  logic             pol,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic             hi_rd,
  input  logic             lo_rd,
  input  logic             stat_rd,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic             take,
  output logic             lock
);
  import cap_timer16_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, hit, armed, flag_arm;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[i] <= 1'b0;
      else if (i == 0) sync_q[i] <= cap_raw;
      else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign hit  = edge_hit(pol, sync_q[SYNC_STAGES-1], prev_q);
  assign take = run && !lock && (hit || armed);

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else if (!run && hit && !lock) armed <= 1'b1;
    else if (take) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cap_val <= '0;
    else if (take) cap_val <= cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lock <= 1'b0;
    else if (hi_rd) lock <= 1'b1;
    else if (lo_rd) lock <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_flag <= 1'b0;
      flag_arm <= 1'b0;
    end else begin
      if (stat_rd && cap_flag) flag_arm <= 1'b1;
      if (lo_rd && flag_arm) begin
        cap_flag <= 1'b0;
        flag_arm <= 1'b0;
      end
      if (take) cap_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/cap_timer16.sv
module cap_timer16 #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] RST_VAL = 16'hFFFC
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cap_in,
  input  logic       stop_i,
  output logic       irq_o
);
  import cap_timer16_pkg::*;
  localparam int unsigned HI_LSB = CNT_W - BYTE_W;

  logic             cap_ie, ovf_ie, pol_q;
  logic [CNT_W-1:0] cnt_q, cap_val;
  logic [BYTE_W-1:0] lo_view;
  logic             ovf_flag, cnt_wrap, cap_flag, cap_take, cap_lock;
  logic             run, ctrl_wr, stat_rd, cnt_hi_rd, cnt_lo_rd, alt_hi_rd, alt_lo_rd;
  logic             cap_hi_rd, cap_lo_rd;
  logic             unused_wbits;

  assign unused_wbits = ^wdata[7:3];
  assign run       = !stop_i;
  assign ctrl_wr   = wr_en && (sel == REG_CTRL);
  assign stat_rd   = rd_en && (sel == REG_STAT);
  assign cnt_hi_rd = rd_en && (sel == REG_CNT_HI);
  assign cnt_lo_rd = rd_en && (sel == REG_CNT_LO);
  assign alt_hi_rd = rd_en && (sel == REG_ALT_HI);
  assign alt_lo_rd = rd_en && (sel == REG_ALT_LO);
  assign cap_hi_rd = rd_en && (sel == REG_CAP_HI);
  assign cap_lo_rd = rd_en && (sel == REG_CAP_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_ie <= 1'b0;
      ovf_ie <= 1'b0;
    end else if (ctrl_wr) begin
      cap_ie <= wdata[0];
      ovf_ie <= wdata[1];
    end
  end

  // edge polarity is deliberately left untouched by reset
  always_ff @(posedge clk) begin
    if (ctrl_wr) pol_q <= wdata[2];
  end

  tm_counter #(.CNT_W(CNT_W), .RST_VAL(RST_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hi_rd(cnt_hi_rd || alt_hi_rd), .lo_rd(cnt_lo_rd || alt_lo_rd),
    .stat_rd(stat_rd), .main_lo_rd(cnt_lo_rd),
    .cnt(cnt_q), .lo_view(lo_view), .ovf_flag(ovf_flag), .wrap(cnt_wrap)
  );

  tm_capture #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_raw(cap_in), .pol(pol_q), .run(run),
    .cnt(cnt_q), .hi_rd(cap_hi_rd), .lo_rd(cap_lo_rd), .stat_rd(stat_rd),
    .cap_val(cap_val), .cap_flag(cap_flag), .take(cap_take), .lock(cap_lock)
  );

  always_comb begin
    unique case (reg_sel_e'(sel))
      REG_CTRL:   rdata = {5'b0, pol_q, ovf_ie, cap_ie};
      REG_STAT:   rdata = {6'b0, ovf_flag, cap_flag};
      REG_CNT_HI,
      REG_ALT_HI: rdata = cnt_q[CNT_W-1:HI_LSB];
      REG_CNT_LO,
      REG_ALT_LO: rdata = lo_view;
      REG_CAP_HI: rdata = cap_val[CNT_W-1:HI_LSB];
      REG_CAP_LO: rdata = cap_val[BYTE_W-1:0];
      default:    rdata = '0;
    endcase
  end

  assign irq_o = (cap_flag && cap_ie) || (ovf_flag && ovf_ie);
endmodule

// File: rtl/cap_timer16_chk.sv
module cap_timer16_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_i,
  input logic             rd_en,
  input logic [2:0]       sel,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic             cnt_wrap,
  input logic             ovf_flag,
  input logic             cap_flag,
  input logic             cap_take,
  input logic             cap_lock,
  input logic [CNT_W-1:0] cap_val
);
  import cap_timer16_pkg::*;

  // R2
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_i |=> cnt == $past(cnt) + 1'b1);

  // R9
  a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> $stable(cnt));

  // R9
  a_r9_no_take_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |-> !cap_take);

  // R5
  a_r5_wrap_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wrap |=> ovf_flag);

  // R4
  a_r4_take_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cap_take |=> cap_flag && cap_val == $past(cnt));

  // R6
  a_r6_lock_holds_value: assert property (@(posedge clk) disable iff (!rst_n)
    cap_lock |=> $stable(cap_val));

  // R7
  a_r7_alt_keeps_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && rd_en && (sel == REG_ALT_LO || sel == REG_ALT_HI)) |=> ovf_flag);

  // R10
  a_r10_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_flag && !ovf_flag) |-> !irq_o);
endmodule

bind cap_timer16 cap_timer16_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .rd_en(rd_en), .sel(sel),
  .irq_o(irq_o), .cnt(cnt_q), .cnt_wrap(cnt_wrap), .ovf_flag(ovf_flag),
  .cap_flag(cap_flag), .cap_take(cap_take), .cap_lock(cap_lock), .cap_val(cap_val)
);

// File: tb/cap_timer16_tb_top.sv
module cap_timer16_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'd0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       cap_in = 1'b0, stop_i = 1'b0;
  logic       irq_o;

  int total = 0;
  int bad = 0;
  logic [15:0] m;      // bench model of the count
  logic [15:0] rd_m;   // model value at the moment of the last read

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) m <= 16'hFFFC;
    else if (!stop_i) m <= m + 16'd1;
  end

  cap_timer16 dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .stop_i(stop_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk);
    sel = s; rd_en = 1'b1;
    #1 d = rdata; rd_m = m;
    @(posedge clk);
    #1 rd_en = 1'b0;
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] v);
    @(negedge clk);
    sel = s; wdata = v; wr_en = 1'b1;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // drives cap_in and returns the count the design must capture if it takes the edge
  task automatic pulse(input logic v, output logic [15:0] e);
    @(negedge clk);
    cap_in = v;
    @(posedge clk);
    @(posedge clk);
    #1 e = m;
    @(posedge clk);
    #1;
  endtask

  task automatic rd16(input logic [2:0] hi_sel, output logic [15:0] v, output logic [15:0] mv);
    logic [7:0] h, l;
    rd(hi_sel, h);
    mv = rd_m;
    rd(hi_sel + 3'd1, l);
    v = {h, l};
  endtask

  task automatic t_reset;
    logic [15:0] v, mv;
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd16(3'd2, v, mv);
    check("R1 count one clock after reset", v, 16'hFFFD);
    rd(3'd1, d);
    check("R1 status after reset", {8'd0, d}, 16'h0000);
    rd(3'd0, d);
    check("R1 enables after reset", {14'd0, d[1:0]}, 16'h0000);
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    logic [15:0] v, mv;
    repeat (4) @(posedge clk);
    rd(3'd1, d);
    check("R5 overflow flag after wrap", {15'd0, d[1]}, 16'd1);
    rd16(3'd4, v, mv);
    check("R3 alternate path coherent", v, mv);
    rd(3'd1, d);
    check("R7 alternate read keeps overflow", {15'd0, d[1]}, 16'd1);
    wr(3'd0, 8'h02);
    #1 check("R10 overflow irq", {15'd0, irq_o}, 16'd1);
    rd(3'd3, d);
    rd(3'd1, d);
    check("R5 overflow cleared", {15'd0, d[1]}, 16'd0);
    check("R10 irq drops with flag", {15'd0, irq_o}, 16'd0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_count;
    logic [15:0] v, mv;
    rd16(3'd2, v, mv);
    check("R3 main path coherent", v, mv);
    wr(3'd2, 8'h12);
    wr(3'd3, 8'h34);
    rd16(3'd2, v, mv);
    check("R2 writes ignored, count follows clocks", v, mv);
  endtask

  task automatic t_cap_rise;
    logic [15:0] e, v, mv;
    logic [7:0] d;
    wr(3'd0, 8'h04);
    pulse(1'b1, e);
    rd(3'd1, d);
    check("R4 rising edge sets flag", {15'd0, d[0]}, 16'd1);
    rd16(3'd6, v, mv);
    check("R4 rising capture value", v, e);
    rd(3'd1, d);
    check("R8 flag cleared by status then low", {15'd0, d[0]}, 16'd0);
    pulse(1'b0, e);
    rd(3'd1, d);
    check("R4 falling edge ignored when rising selected", {15'd0, d[0]}, 16'd0);
  endtask

  task automatic t_cap_fall;
    logic [15:0] e, v, mv;
    logic [7:0] d;
    wr(3'd0, 8'h00);
    pulse(1'b1, e);
    rd(3'd1, d);
    check("R4 rising edge ignored when falling selected", {15'd0, d[0]}, 16'd0);
    pulse(1'b0, e);
    rd16(3'd6, v, mv);
    check("R4 falling capture value", v, e);
    rd(3'd1, d);
    check("R4 falling edge sets flag", {15'd0, d[0]}, 16'd1);
    rd(3'd7, d);
  endtask

  task automatic t_lock;
    logic [15:0] e1, e2, e3, v, mv;
    logic [7:0] d, h;
    wr(3'd0, 8'h04);
    pulse(1'b1, e1);
    rd(3'd6, h);
    pulse(1'b0, e2);
    pulse(1'b1, e2);
    rd(3'd7, d);
    check("R6 capture blocked while high byte held", {h, d}, e1);
    rd(3'd1, d);
    check("R8 low read without status keeps flag", {15'd0, d[0]}, 16'd1);
    rd16(3'd6, v, mv);
    check("R6 blocked edge left value", v, e1);
    pulse(1'b0, e3);
    pulse(1'b1, e3);
    rd16(3'd6, v, mv);
    check("R6 capture resumes after low read", v, e3);
  endtask

  task automatic t_stop;
    logic [15:0] v, mv, hold, e;
    logic [7:0] d;
    rd(3'd1, d);
    rd(3'd7, d);
    @(negedge clk);
    stop_i = 1'b1;
    @(posedge clk);
    #1 hold = m;
    rd16(3'd2, v, mv);
    check("R9 count held in stop", v, hold);
    pulse(1'b0, e);
    pulse(1'b1, e);
    rd(3'd1, d);
    check("R9 no flag in stop", {15'd0, d[0]}, 16'd0);
    rd16(3'd2, v, mv);
    check("R9 count still held", v, hold);
    @(negedge clk);
    stop_i = 1'b0;
    repeat (2) @(posedge clk);
    rd(3'd1, d);
    check("R9 deferred edge sets flag", {15'd0, d[0]}, 16'd1);
    rd16(3'd6, v, mv);
    check("R9 deferred capture uses held count", v, hold);
    rd16(3'd2, v, mv);
    check("R2 count resumes", v, mv);
  endtask

  task automatic t_irq;
    logic [15:0] e;
    logic [7:0] d;
    wr(3'd0, 8'h05);
    pulse(1'b0, e);
    pulse(1'b1, e);
    check("R10 capture irq", {15'd0, irq_o}, 16'd1);
    wr(3'd0, 8'h04);
    #1 check("R10 irq masked", {15'd0, irq_o}, 16'd0);
    wr(3'd0, 8'h05);
    rd(3'd1, d);
    rd(3'd7, d);
    #1 check("R10 irq clears with flag", {15'd0, irq_o}, 16'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_overflow();
    t_count();
    t_cap_rise();
    t_cap_fall();
    t_lock();
    t_stop();
    t_irq();
    repeat (2) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule